// File: doc/BRIEF.md
# Full-Speed Frame Timer

This block paces the frame structure of a full-speed USB host controller. It counts in 12 MHz bit times, signalled to it by a one-clock strobe. At each frame boundary it reloads a down-counter holding the bit times left in the frame. At the same boundary it reloads a second down-counter, the largest-packet budget, and advances a 16-bit frame number. It pulses a start-of-frame strobe for one clock.

Within each frame it raises a periodic-window flag once the remaining time has fallen to a programmable threshold. It also answers, combinationally, whether a transaction of a stated bit length still fits inside the current packet budget. The list scheduler uses both answers. Two configuration words are written and read through a small select/strobe interface.

The control is a three-state machine. HALT means the frame timer is stopped. EARLY is the non-periodic part of a frame. PERIODIC is the periodic window. The transitions are:
- START: HALT to EARLY on the first tick while running, which reloads the counters.
- ENTER_WINDOW: EARLY to PERIODIC on a tick that leaves the remaining count at or below the threshold.
- WRAP: EARLY or PERIODIC to EARLY on a tick that finds the remaining count at zero, which reloads the counters.
- STOP: any state to HALT whenever `run` is low.

A tick in EARLY that neither reaches the threshold nor finds zero stays in EARLY. A tick in PERIODIC that does not find zero stays in PERIODIC.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, `frame_num`, `frame_left`, `pkt_budget`, `sof_pulse`, `periodic_go` and `pkt_fits` are 0. The interval word reads back with length 12000 and packet budget 10105, which is (12000 - 210) * 6 / 7. The threshold word reads back 10800.
- R2: The counters and the frame number change only on a clock where `run` and `bit_tick` are both high. With `bit_tick` low they hold.
- R3: A tick that finds `frame_left` at 0 starts a new frame, and so does the first tick after HALT. On that tick `frame_left` loads the length minus one, or 0 when the length field is 0. `pkt_budget` loads the budget field and `frame_num` increments by one. `sof_pulse` is high for exactly the next clock.
- R4: Any other tick decrements `frame_left` by one.
- R5: Any other tick decrements `pkt_budget` by one while it is nonzero. At 0 it stays 0.
- R6: When `cfg_sel` is 0, the write data carries the frame length in bits 13:0 and the packet budget in bits 30:16. When `cfg_sel` is 1, bits 13:0 carry the threshold. Reads return the stored words with all other bits 0. A length or budget write is seen by the counters only at the next frame start.
- R7: `periodic_go` rises after a non-reload tick that leaves `frame_left` at or below the threshold. It stays high until the next frame start or stop. A threshold write acts from the next tick on.
- R8: `pkt_fits` is high exactly when the timer is not halted and `pkt_len` is at most `pkt_budget`.
- R9: With `run` low the timer is halted. The counters hold, and `periodic_go` and `pkt_fits` are 0. The next tick after `run` returns starts a new frame.
- R10: The frame number wraps from 65535 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timer enable; low halts |
| bit_tick | input | 1 | One-clock strobe per bit time |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word select: 0 length/budget, 1 threshold |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected configuration word |
| pkt_len | input | 16 | Transaction length in bit times to test |
| pkt_fits | output | 1 | Transaction fits the current budget |
| sof_pulse | output | 1 | Start-of-frame strobe |
| frame_num | output | 16 | Current frame number |
| frame_left | output | 14 | Bit times left in the frame |
| pkt_budget | output | 15 | Largest-packet budget counter |
| periodic_go | output | 1 | Periodic window open |

## Verification
The hardest situation to reach is the wrap of the frame number, because a normal frame lasts thousands of ticks. The stimulus writes a zero frame length, so that every tick starts a frame, and holds the tick high for more than 65536 clocks. A second hard situation is a length write landing mid-frame, whose effect must appear only after the old frame drains. The bench writes a short length while the counters are still counting the previous one and waits for the next start strobe.

// File: rtl/usb_ft_pkg.sv
package usb_ft_pkg;
    localparam int FT_FI_W     = 14;
    localparam int FT_LP_W     = 15;
    localparam int FT_FN_W     = 16;
    localparam int FT_DATA_W   = 32;
    localparam int FT_LP_LSB   = 16;
    localparam int FT_DEF_FI   = 12000;
    localparam int FT_OVERHEAD = 210;
    localparam int FT_DEF_LP   = ((FT_DEF_FI - FT_OVERHEAD) * 6) / 7;
    localparam int FT_DEF_PS   = (FT_DEF_FI * 90) / 100;

    typedef enum logic [1:0] {
        FT_HALT     = 2'd0,
        FT_EARLY    = 2'd1,
        FT_PERIODIC = 2'd2
    } ft_state_e;
endpackage

// File: rtl/usb_ft_regs.sv
module usb_ft_regs #(
    parameter int FI_W   = 14,
    parameter int LP_W   = 15,
    parameter int DATA_W = 32,
    parameter int LP_LSB = 16,
    parameter int DEF_FI = 12000,
    parameter int DEF_LP = 10105,
    parameter int DEF_PS = 10800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [FI_W-1:0]   fi_q,
    output logic [LP_W-1:0]   lp_q,
    output logic [FI_W-1:0]   ps_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fi_q <= FI_W'(DEF_FI);
            lp_q <= LP_W'(DEF_LP);
            ps_q <= FI_W'(DEF_PS);
        end else if (wr) begin
            if (!sel) begin
                fi_q <= wdata[FI_W-1:0];
                lp_q <= wdata[LP_LSB +: LP_W];
            end else begin
                ps_q <= wdata[FI_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (!sel) begin
            rdata[FI_W-1:0]       = fi_q;
            rdata[LP_LSB +: LP_W] = lp_q;
        end else begin
            rdata[FI_W-1:0] = ps_q;
        end
    end
endmodule

// File: rtl/usb_ft_ctrl.sv
module usb_ft_ctrl
    import usb_ft_pkg::*;
#(
    parameter int FI_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            bit_tick,
    input  logic [FI_W-1:0] rem_q,
    input  logic [FI_W-1:0] ps_q,
    output logic            reload,
    output logic            step,
    output logic            running,
    output logic            periodic
);
    ft_state_e state_q, state_d;
    logic      rem_zero;
    logic      hit_window;

    assign rem_zero   = (rem_q == '0);
    assign hit_window = ((rem_q - FI_W'(1)) <= ps_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FT_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = FT_HALT;
        end else begin
            unique case (state_q)
                FT_HALT:     if (bit_tick) state_d = FT_EARLY;
                FT_EARLY: begin
                    if (bit_tick && !rem_zero && hit_window) state_d = FT_PERIODIC;
                end
                FT_PERIODIC: if (bit_tick && rem_zero) state_d = FT_EARLY;
                default:     state_d = FT_HALT;
            endcase
        end
    end

    always_comb begin
        reload   = 1'b0;
        step     = 1'b0;
        running  = 1'b0;
        periodic = 1'b0;
        unique case (state_q)
            FT_HALT: begin
                reload = run && bit_tick;
            end
            FT_EARLY: begin
                running = 1'b1;
                reload  = run && bit_tick && rem_zero;
                step    = run && bit_tick && !rem_zero;
            end
            FT_PERIODIC: begin
                running  = 1'b1;
                periodic = 1'b1;
                reload   = run && bit_tick && rem_zero;
                step     = run && bit_tick && !rem_zero;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/usb_ft_counters.sv
module usb_ft_counters #(
    parameter int FI_W = 14,
    parameter int LP_W = 15,
    parameter int FN_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload,
    input  logic            step,
    input  logic [FI_W-1:0] fi_q,
    input  logic [LP_W-1:0] lp_q,
    output logic [FI_W-1:0] rem_q,
    output logic [LP_W-1:0] budget_q,
    output logic [FN_W-1:0] frame_q,
    output logic            sof_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            budget_q <= '0;
            frame_q  <= '0;
            sof_q    <= 1'b0;
        end else begin
            sof_q <= reload;
            if (reload) begin
                rem_q    <= (fi_q == '0) ? '0 : fi_q - FI_W'(1);
                budget_q <= lp_q;
                frame_q  <= frame_q + FN_W'(1);
            end else if (step) begin
                rem_q <= rem_q - FI_W'(1);
                if (budget_q != '0) budget_q <= budget_q - LP_W'(1);
            end
        end
    end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import usb_ft_pkg::*;
#(
    parameter int FI_W   = FT_FI_W,
    parameter int LP_W   = FT_LP_W,
    parameter int FN_W   = FT_FN_W,
    parameter int DATA_W = FT_DATA_W,
    parameter int LP_LSB = FT_LP_LSB,
    parameter int DEF_FI = FT_DEF_FI,
    parameter int DEF_LP = FT_DEF_LP,
    parameter int DEF_PS = FT_DEF_PS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              bit_tick,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [LP_W:0]     pkt_len,
    output logic              pkt_fits,
    output logic              sof_pulse,
    output logic [FN_W-1:0]   frame_num,
    output logic [FI_W-1:0]   frame_left,
    output logic [LP_W-1:0]   pkt_budget,
    output logic              periodic_go
);
    logic [FI_W-1:0] fi_q;
    logic [LP_W-1:0] lp_q;
    logic [FI_W-1:0] ps_q;
    logic            reload;
    logic            step;
    logic            running;

    usb_ft_regs #(
        .FI_W(FI_W), .LP_W(LP_W), .DATA_W(DATA_W), .LP_LSB(LP_LSB),
        .DEF_FI(DEF_FI), .DEF_LP(DEF_LP), .DEF_PS(DEF_PS)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .fi_q(fi_q), .lp_q(lp_q), .ps_q(ps_q)
    );

    usb_ft_ctrl #(.FI_W(FI_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .run(run), .bit_tick(bit_tick),
        .rem_q(frame_left), .ps_q(ps_q),
        .reload(reload), .step(step), .running(running), .periodic(periodic_go)
    );

    usb_ft_counters #(.FI_W(FI_W), .LP_W(LP_W), .FN_W(FN_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .reload(reload), .step(step),
        .fi_q(fi_q), .lp_q(lp_q),
        .rem_q(frame_left), .budget_q(pkt_budget),
        .frame_q(frame_num), .sof_q(sof_pulse)
    );

    assign pkt_fits = running && (pkt_len <= {1'b0, pkt_budget});
endmodule

// File: rtl/usb_frame_timer_chk.sv
module usb_frame_timer_chk #(
    parameter int FI_W = 14,
    parameter int LP_W = 15,
    parameter int FN_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic            bit_tick,
    input logic            sof_pulse,
    input logic [FN_W-1:0] frame_num,
    input logic [FI_W-1:0] frame_left,
    input logic [LP_W-1:0] pkt_budget,
    input logic            periodic_go
);
    AST_SOF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> $past(run && bit_tick)); // R3
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_num != $past(frame_num)) |-> (sof_pulse && frame_num == $past(frame_num) + FN_W'(1))); // R10
    AST_LEFT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_left != $past(frame_left)) |-> (sof_pulse || frame_left == $past(frame_left) - FI_W'(1))); // R4
    AST_BUDGET_NONRISING: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_pulse |-> (pkt_budget <= $past(pkt_budget))); // R5
    AST_WINDOW_CLOSED_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> !periodic_go); // R7
    AST_WINDOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periodic_go) |-> (sof_pulse || $past(!run))); // R9
endmodule

bind usb_frame_timer usb_frame_timer_chk #(.FI_W(FI_W), .LP_W(LP_W), .FN_W(FN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .run(run), .bit_tick(bit_tick),
    .sof_pulse(sof_pulse), .frame_num(frame_num), .frame_left(frame_left),
    .pkt_budget(pkt_budget), .periodic_go(periodic_go)
);

// File: tb/usb_frame_timer_tb_top.sv
`timescale 1ns/1ps
module usb_frame_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        bit_tick = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] pkt_len = '0;
    logic        pkt_fits;
    logic        sof_pulse;
    logic [15:0] frame_num;
    logic [13:0] frame_left;
    logic [14:0] pkt_budget;
    logic        periodic_go;

    always #2.5 clk = ~clk;

    usb_frame_timer dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .bit_tick(bit_tick),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pkt_len(pkt_len), .pkt_fits(pkt_fits),
        .sof_pulse(sof_pulse), .frame_num(frame_num), .frame_left(frame_left),
        .pkt_budget(pkt_budget), .periodic_go(periodic_go)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    bit wrap_seen = 1'b0;
    bit done = 1'b0;

    // behavioural reference: 0 halted, 1 early part, 2 periodic window
    int m_st, m_rem, m_lpc, m_fn, m_sof, m_fi, m_lp, m_ps;

    task automatic check(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_rem = 0; m_lpc = 0; m_fn = 0; m_sof = 0;
            m_fi = 12000; m_lp = 10105; m_ps = 10800;
        end else begin
            m_sof = 0;
            if (!run) begin
                m_st = 0;
            end else if (bit_tick) begin
                if (m_st == 0 || m_rem == 0) begin
                    m_rem = (m_fi == 0) ? 0 : m_fi - 1;
                    m_lpc = m_lp;
                    m_fn  = (m_fn + 1) % 65536;
                    m_sof = 1;
                    m_st  = 1;
                end else begin
                    m_rem = m_rem - 1;
                    if (m_lpc > 0) m_lpc = m_lpc - 1;
                    if (m_st == 1 && m_rem <= m_ps) m_st = 2;
                end
            end
            if (cfg_wr) begin
                if (!cfg_sel) begin
                    m_fi = cfg_wdata[13:0];
                    m_lp = cfg_wdata[30:16];
                end else begin
                    m_ps = cfg_wdata[13:0];
                end
            end
        end
    end

    logic [15:0] prev_fn = '0;
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check("R3 sof_pulse", sof_pulse, m_sof);
            check("R3 frame_num", frame_num, m_fn);
            check("R4 frame_left", frame_left, m_rem);
            check("R5 pkt_budget", pkt_budget, m_lpc);
            check("R7 periodic_go", periodic_go, (m_st == 2));
            check("R8 pkt_fits", pkt_fits, (m_st != 0 && int'(pkt_len) <= m_lpc));
            check("R6 cfg_rdata", cfg_rdata,
                  cfg_sel ? longint'(m_ps) : ((longint'(m_lp) << 16) | m_fi));
            if (prev_fn == 16'hFFFF && frame_num == 16'h0000) wrap_seen = 1'b1;
            prev_fn = frame_num;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    task automatic cycles(int n, int tick_mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            cfg_wr   = 1'b0;
            bit_tick = (tick_mode == 2) ? 1'($urandom_range(0, 1)) : 1'(tick_mode);
            pkt_len  = 16'($urandom_range(0, 24));
        end
    endtask

    task automatic cfg_write(bit sel, logic [31:0] data);
        @(negedge clk); #1;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    endtask

    initial begin
        int held;
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        check("R1 frame_num", frame_num, 0);
        check("R1 frame_left", frame_left, 0);
        check("R1 sof_pulse", sof_pulse, 0);
        check("R1 periodic_go", periodic_go, 0);
        check("R1 pkt_fits", pkt_fits, 0);
        cfg_sel = 1'b0; #0.1;
        check("R1 interval word", cfg_rdata, (10105 << 16) | 12000);
        cfg_sel = 1'b1; #0.1;
        check("R1 threshold word", cfg_rdata, 10800);

        cfg_write(1'b0, (32'd12 << 16) | 32'd20);
        cfg_write(1'b1, 32'd6);
        run = 1'b1;
        cycles(60, 1);
        cycles(150, 2);

        // R2: no tick, nothing moves
        cycles(1, 0);
        held = frame_left;
        cycles(10, 0);
        check("R2 frame_left held", frame_left, held);

        // R6: length change mid-frame waits for boundary
        cycles(3, 1);
        cfg_write(1'b0, (32'd4 << 16) | 32'd9);
        bit_tick = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sof_pulse) break;
        end
        check("R6 new length at boundary", frame_left, 8);
        check("R6 new budget at boundary", pkt_budget, 4);

        // R7: threshold raised mid-frame opens window on next tick
        cycles(1, 0);
        cfg_write(1'b1, 32'd15);
        cycles(1, 1);
        cycles(1, 0);
        check("R7 window after threshold write", periodic_go, 1);
        cycles(40, 2);

        // R5: budget saturates at zero
        cfg_write(1'b0, (32'd3 << 16) | 32'd30);
        cycles(40, 1);
        cycles(1, 0);
        check("R5 budget saturated", pkt_budget, 0);

        // R9: halt and restart
        run = 1'b0;
        cycles(1, 1);
        held = frame_left;
        cycles(5, 1);
        check("R9 halted window", periodic_go, 0);
        check("R9 halted fits", pkt_fits, 0);
        check("R9 halted frame_left", frame_left, held);
        run = 1'b1;
        cycles(1, 1);
        check("R9 restart sof", sof_pulse, 1);
        cycles(30, 2);

        // R10: zero length, one frame per tick, run through the wrap
        cfg_write(1'b0, (32'd7 << 16) | 32'd0);
        cycles(65545, 1);
        check("R10 frame number wrapped", wrap_seen, 1);
        cycles(5, 2);
        finish_run();
    end
endmodule